// File: doc/BRIEF.md
# Translation Fault Capture with Pseudo-Random Refill Way

This block sits beside a four-way set-associative translation buffer. When a lookup fails, whether because no entry matched or because a matching entry forbade the access, it records what went wrong in two software-visible registers. It also names the way that the refill handler should overwrite. The register contents and the chosen way are presented continuously at the ports. The buffer storage, the lookup logic, exception routing and the register bus all sit outside the block.

The way choice for a clean miss comes from a 16-bit right-shifting pseudo-random register. That register steps once per real fault. Lookups marked as debug accesses leave the generator and both registers untouched, so a debugger that probes addresses does not disturb the sequence or the captured state. Software may overwrite either register through a single-cycle write strobe. A fault capture in the same cycle wins over that write.

Top module: `tlb_miss_capture`

## Requirements
- R1: After reset the pseudo-random state is 16'hCCCC, so the chosen way on a miss is 0, and both registers read 0.
- R2: Each step computes a feedback bit equal to the parity of (state AND 16'h8805). The state then shifts right by one, and the feedback bit enters bit 15.
- R3: The generator steps on every cycle where `fault_i` is high and `debug_i` is low, whether or not the fault had a hit. It holds in all other cycles, including cycles with software writes.
- R4: A fault with `debug_i` high changes neither register nor the generator. This holds for both misses and hits.
- R5: `victim_way_o` equals `hit_way_i` when `hit_i` is high. Otherwise it equals the low two bits of the current generator state, taken before any step.
- R6: A captured fault replaces the select register with zero, except for two fields. Bits [3:0] hold page-number bits [3:0], and bits [5:4] hold the way from R5.
- R7: A captured fault writes the current process ID into cause bits [7:0] and the 19-bit page number (address bits [31:13] of an 8 KB page) into bits [31:13]. Bits [12:10] keep their previous value.
- R8: Cause bits [9:8] hold the access-type code from `acc_type_i`: 0 read, 1 write, 2 execute.
- R9: A software write strobe loads the full 32-bit word into its register. When a captured fault occurs in the same cycle, the fault result replaces the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_i | input | 1 | Lookup failed this cycle |
| debug_i | input | 1 | Failing lookup is a debug access |
| vpn_i | input | 19 | Virtual page number (address bits [31:13]) |
| pid_i | input | 8 | Current process ID |
| acc_type_i | input | 2 | Access type: 0 read, 1 write, 2 execute |
| hit_i | input | 1 | An entry matched (protection fault) |
| hit_way_i | input | 2 | Way of the matching entry |
| sw_wr_sel_i | input | 1 | Software write strobe for select register |
| sw_wr_cause_i | input | 1 | Software write strobe for cause register |
| sw_wdata_i | input | 32 | Software write data |
| victim_way_o | output | 2 | Way to report or refill |
| sel_reg_o | output | 32 | Select register contents |
| cause_reg_o | output | 32 | Cause register contents |

## Verification
A corrupted generator state shows at `victim_way_o` right away on any miss, and at select bits [5:4] one edge after the next captured fault. The bench keeps its own copy of the generator and compares the way after every fault over a long run. A wrong tap or a missed or extra step therefore produces a mismatch within a few faults. A cause-register merge that drops the preserved bits shows on the first capture after software has set them.

// File: rtl/mcap_pkg.sv
package mcap_pkg;
  localparam int MCAP_REG_W  = 32;
  localparam int MCAP_LFSR_W = 16;
  localparam logic [MCAP_LFSR_W-1:0] MCAP_SEED = 16'hCCCC;
  localparam logic [MCAP_LFSR_W-1:0] MCAP_TAPS = 16'h8805;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } acc_e;
endpackage

// File: rtl/mcap_lfsr.sv
module mcap_lfsr #(
  parameter int W = 16,
  parameter logic [W-1:0] SEED = '1,
  parameter logic [W-1:0] TAPS = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] q;
  logic [W-1:0] tapped;

  function automatic logic [W-1:0] advance(input logic [W-1:0] s, input logic [W-1:0] t);
    logic fb;
    fb = ^(s & t);
    return {fb, s[W-1:1]};
  endfunction

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_tap
      assign tapped[gi] = TAPS[gi] ? q[gi] : 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)       q <= SEED;
    else if (step_i)  q <= advance(q, TAPS);
  end

  assign state_o = q;

  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(q)); // R3
  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    q != '0); // R2
  AST_LFSR_FEED: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> q[W-1] == $past(^tapped)); // R2
endmodule

// File: rtl/mcap_sel_reg.sv
module mcap_sel_reg #(
  parameter int REG_W = 32,
  parameter int IDX_W = 4,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [WAY_W-1:0] way_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] q_o
);
  localparam int WAY_LO = IDX_W;
  localparam int WAY_HI = IDX_W + WAY_W - 1;

  function automatic logic [REG_W-1:0] pack_sel(input logic [IDX_W-1:0] idx,
                                                input logic [WAY_W-1:0] way);
    logic [REG_W-1:0] r;
    r = '0;
    r[IDX_W-1:0] = idx;
    r[WAY_HI:WAY_LO] = way;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= '0;
    else if (cap_i) q_o <= pack_sel(idx_i, way_i);
    else if (wr_i)  q_o <= wdata_i;
  end

  AST_SEL_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> q_o[REG_W-1:WAY_HI+1] == '0); // R6
  AST_SEL_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> q_o[WAY_HI:WAY_LO] == $past(way_i)); // R6
endmodule

// File: rtl/mcap_cause_reg.sv
module mcap_cause_reg #(
  parameter int REG_W = 32,
  parameter int PID_W = 8,
  parameter int VPN_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [PID_W-1:0] pid_i,
  input  logic [1:0]       acc_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] q_o
);
  localparam int ACC_LO  = PID_W;
  localparam int ACC_HI  = PID_W + 1;
  localparam int VPN_LO  = REG_W - VPN_W;
  localparam int KEEP_LO = ACC_HI + 1;
  localparam int KEEP_HI = VPN_LO - 1;

  function automatic logic [REG_W-1:0] merge_cause(input logic [REG_W-1:0] old,
                                                   input logic [PID_W-1:0] pid,
                                                   input logic [1:0] acc,
                                                   input logic [VPN_W-1:0] vpn);
    logic [REG_W-1:0] r;
    r = old;
    r[PID_W-1:0] = pid;
    r[ACC_HI:ACC_LO] = acc;
    r[REG_W-1:VPN_LO] = vpn;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= '0;
    else if (cap_i) q_o <= merge_cause(q_o, pid_i, acc_i, vpn_i);
    else if (wr_i)  q_o <= wdata_i;
  end

  AST_CAUSE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> q_o[KEEP_HI:KEEP_LO] == $past(q_o[KEEP_HI:KEEP_LO])); // R7
  AST_CAUSE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> q_o[REG_W-1:VPN_LO] == $past(vpn_i)); // R7
  AST_CAUSE_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> q_o[ACC_HI:ACC_LO] == $past(acc_i)); // R8
endmodule

// File: rtl/tlb_miss_capture.sv
module tlb_miss_capture
  import mcap_pkg::*;
#(
  parameter int VPN_W  = 19,
  parameter int PID_W  = 8,
  parameter int IDX_W  = 4,
  parameter int WAY_W  = 2,
  parameter int REG_W  = MCAP_REG_W,
  parameter int LFSR_W = MCAP_LFSR_W,
  parameter logic [LFSR_W-1:0] SEED = MCAP_SEED,
  parameter logic [LFSR_W-1:0] TAPS = MCAP_TAPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_i,
  input  logic             debug_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [PID_W-1:0] pid_i,
  input  logic [1:0]       acc_type_i,
  input  logic             hit_i,
  input  logic [WAY_W-1:0] hit_way_i,
  input  logic             sw_wr_sel_i,
  input  logic             sw_wr_cause_i,
  input  logic [REG_W-1:0] sw_wdata_i,
  output logic [WAY_W-1:0] victim_way_o,
  output logic [REG_W-1:0] sel_reg_o,
  output logic [REG_W-1:0] cause_reg_o
);
  logic              cap_evt;
  logic              dbg_evt;
  logic [LFSR_W-1:0] rnd_state;
  logic [WAY_W-1:0]  rnd_way;
  logic [IDX_W-1:0]  set_idx;

  assign cap_evt = fault_i & ~debug_i;
  assign dbg_evt = fault_i & debug_i;
  assign rnd_way = rnd_state[WAY_W-1:0];
  assign set_idx = vpn_i[IDX_W-1:0];

  function automatic logic [WAY_W-1:0] pick_way(input logic hit,
                                                input logic [WAY_W-1:0] hway,
                                                input logic [WAY_W-1:0] rway);
    return hit ? hway : rway;
  endfunction

  assign victim_way_o = pick_way(hit_i, hit_way_i, rnd_way);

  mcap_lfsr #(.W(LFSR_W), .SEED(SEED), .TAPS(TAPS)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step_i(cap_evt), .state_o(rnd_state)
  );

  mcap_sel_reg #(.REG_W(REG_W), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .cap_i(cap_evt), .idx_i(set_idx),
    .way_i(victim_way_o), .wr_i(sw_wr_sel_i), .wdata_i(sw_wdata_i), .q_o(sel_reg_o)
  );

  mcap_cause_reg #(.REG_W(REG_W), .PID_W(PID_W), .VPN_W(VPN_W)) u_cause (
    .clk(clk), .rst_n(rst_n), .cap_i(cap_evt), .pid_i(pid_i), .acc_i(acc_type_i),
    .vpn_i(vpn_i), .wr_i(sw_wr_cause_i), .wdata_i(sw_wdata_i), .q_o(cause_reg_o)
  );

  AST_DEBUG_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_evt && !sw_wr_sel_i && !sw_wr_cause_i |=> $stable(sel_reg_o) && $stable(cause_reg_o)); // R4
  AST_DEBUG_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_evt |=> $stable(rnd_state)); // R4
  AST_HIT_WAY_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt && hit_i |=> sel_reg_o[IDX_W+WAY_W-1:IDX_W] == $past(hit_way_i)); // R5
  AST_SW_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_sel_i && !cap_evt |=> sel_reg_o == $past(sw_wdata_i)); // R9
endmodule

// File: tb/tlb_miss_capture_tb.sv
`timescale 1ns/1ps
module tlb_miss_capture_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fault_i = 1'b0, debug_i = 1'b0, hit_i = 1'b0;
  logic [18:0] vpn_i = '0;
  logic [7:0]  pid_i = '0;
  logic [1:0]  acc_type_i = '0, hit_way_i = '0;
  logic        sw_wr_sel_i = 1'b0, sw_wr_cause_i = 1'b0;
  logic [31:0] sw_wdata_i = '0;
  logic [1:0]  victim_way_o;
  logic [31:0] sel_reg_o, cause_reg_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] m_lfsr;
  logic [31:0] m_sel, m_cause;

  always #2.5 clk = ~clk;

  tlb_miss_capture u_dut (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .debug_i(debug_i), .vpn_i(vpn_i),
    .pid_i(pid_i), .acc_type_i(acc_type_i), .hit_i(hit_i), .hit_way_i(hit_way_i),
    .sw_wr_sel_i(sw_wr_sel_i), .sw_wr_cause_i(sw_wr_cause_i), .sw_wdata_i(sw_wdata_i),
    .victim_way_o(victim_way_o), .sel_reg_o(sel_reg_o), .cause_reg_o(cause_reg_o)
  );

  // {debug, hit, hit_way, acc, vpn, pid}
  localparam logic [32:0] VEC [8] = '{
    {1'b0, 1'b0, 2'd0, 2'd0, 19'h00001, 8'h11},
    {1'b0, 1'b0, 2'd0, 2'd1, 19'h7FFFF, 8'hFF},
    {1'b0, 1'b1, 2'd3, 2'd2, 19'h2A5C3, 8'h3C},
    {1'b1, 1'b0, 2'd0, 2'd0, 19'h1234F, 8'h99},
    {1'b0, 1'b0, 2'd0, 2'd2, 19'h0000E, 8'h00},
    {1'b0, 1'b1, 2'd1, 2'd1, 19'h55555, 8'hA5},
    {1'b1, 1'b1, 2'd2, 2'd1, 19'h0ABCD, 8'h42},
    {1'b0, 1'b0, 2'd0, 2'd0, 19'h40008, 8'h01}
  };

  function automatic logic [15:0] model_step(input logic [15:0] s);
    int ones = 0;
    for (int b = 0; b < 16; b++)
      if (s[b] && (b == 0 || b == 2 || b == 11 || b == 15)) ones++;
    return (s >> 1) | (16'(ones % 2) << 15);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive a fault at negedge, check the way before the edge, registers after
  task automatic do_fault(input logic dbg, input logic hit, input logic [1:0] hw,
                          input logic [1:0] acc, input logic [18:0] vpn, input logic [7:0] pid,
                          input string req);
    logic [1:0] exp_way;
    fault_i = 1'b1; debug_i = dbg; hit_i = hit; hit_way_i = hw;
    acc_type_i = acc; vpn_i = vpn; pid_i = pid;
    exp_way = hit ? hw : m_lfsr[1:0];
    #1;
    chk({req, " R5 way"}, {30'd0, victim_way_o}, {30'd0, exp_way});
    @(negedge clk);
    fault_i = 1'b0; debug_i = 1'b0; hit_i = 1'b0;
    if (!dbg) begin
      m_sel = {26'd0, exp_way, vpn[3:0]};
      m_cause = {vpn, m_cause[12:10], acc, pid};
      m_lfsr = model_step(m_lfsr);
    end
    chk({req, " R6 sel"}, sel_reg_o, m_sel);
    chk({req, " R7 R8 cause"}, cause_reg_o, m_cause);
  endtask

  task automatic sw_write(input logic s, input logic c, input logic [31:0] d);
    sw_wr_sel_i = s; sw_wr_cause_i = c; sw_wdata_i = d;
    @(negedge clk);
    sw_wr_sel_i = 1'b0; sw_wr_cause_i = 1'b0;
    if (s) m_sel = d;
    if (c) m_cause = d;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_lfsr = 16'hCCCC; m_sel = '0; m_cause = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sel reset", sel_reg_o, 32'd0);
    chk("R1 cause reset", cause_reg_o, 32'd0);
    chk("R1 way reset", {30'd0, victim_way_o}, 32'd0);

    // table walk: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 8; i++)
      do_fault(VEC[i][32], VEC[i][31], VEC[i][30:29], VEC[i][28:27],
               VEC[i][26:8], VEC[i][7:0], $sformatf("vec%0d", i));

    // R9 software writes load the full word; no generator step (R3)
    sw_write(1'b1, 1'b0, 32'hFFFF_FFFF);
    chk("R9 sel write", sel_reg_o, 32'hFFFF_FFFF);
    sw_write(1'b0, 1'b1, 32'hFFFF_FFFF);
    chk("R9 cause write", cause_reg_o, 32'hFFFF_FFFF);
    chk("R3 no step on write", {30'd0, victim_way_o}, {30'd0, m_lfsr[1:0]});

    // R6 upper bits cleared, R7 bits 12:10 kept
    do_fault(1'b0, 1'b0, 2'd0, 2'd0, 19'h00000, 8'h00, "keep");
    chk("R7 kept bits", {29'd0, cause_reg_o[12:10]}, 32'd7);
    chk("R6 upper clear", {6'd0, sel_reg_o[31:6]}, 32'd0);

    // R4 debug fault leaves registers after software set them
    sw_write(1'b1, 1'b1, 32'h1357_9BDF);
    do_fault(1'b1, 1'b0, 2'd0, 2'd2, 19'h7AAAA, 8'h77, "R4 dbg");

    // R9 fault wins over same-cycle software write
    sw_wr_sel_i = 1'b1; sw_wr_cause_i = 1'b1; sw_wdata_i = 32'hDEAD_BEEF;
    do_fault(1'b0, 1'b1, 2'd2, 2'd1, 19'h3C3C3, 8'h5E, "R9 prio");
    sw_wr_sel_i = 1'b0; sw_wr_cause_i = 1'b0;

    // R2 long run of misses: generator sequence visible through the way
    for (int k = 0; k < 60; k++)
      do_fault(1'b0, 1'b0, 2'd0, 2'(k % 3), 19'(k * 977), 8'(k * 13), "R2 run");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule